// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous Static Memory

This block is a single-port synchronous static memory for use inside a larger chip. All commands are taken on the rising clock edge. A command is the address, the global write enable, the per-lane write enables and a synchronous select, gated by a synchronous power-down input. Reads are pipelined: the array is read on the edge after the command and the word goes into an output register. Writes are late: the word to be written arrives one cycle after its address. It waits in a one-entry write buffer and reaches the array only when the array port is next free.

Because a pending write may not yet be in the array, a read of the same address takes each lane that the pending write covers from the buffer and the rest from the array. This holds even when the read comes in the cycle right after the write command. The data bus is split into an input word, an output word and a drive-enable output, so that the pad tristate stays in the I/O ring. The drive enable follows the output-enable input with no clock involved.

Top module: `lw_sram`

## Requirements
- R1: On each rising edge with `rst_n` high, the block samples `sel`, `pd`, `we_all`, `we_lane` and `addr`. The command is a no-op when `sel` is low or `pd` is high. Otherwise it is a write when `we_all` or any bit of `we_lane` is high, and a read when none of them is.
- R2: A read sampled at edge N loads the output register at edge N+1. If `oe` is high, `dq_o` shows the word and `dq_en` is high through the cycle after edge N+1.
- R3: For a write sampled at edge N, the word is taken from `dq_i` at edge N+1. It is kept until it is committed and is never lost, whatever `dq_i` carries on other edges.
- R4: `we_lane[k]` covers bits `[9k+8:9k]` of the word, and lanes whose enable is low keep their old contents. When `we_all` is high, all four lanes are written whatever `we_lane` holds.
- R5: A read whose address matches a pending buffered write returns that write's lanes merged over the array contents. This includes a read issued in the cycle directly after the write command.
- R6: `dq_en` is low whenever `oe` is low, and it follows changes of `oe` between clock edges without waiting for an edge.
- R7: After a no-op, `dq_en` is low in the following cycle and `dq_o` holds its previous value. After a write, `dq_o` also holds its previous value.
- R8: While `pd` is sampled high, commands are ignored and `dq_en` is low in the following cycle. Array contents and any pending write survive the power-down window.
- R9: `dq_en` is low during the cycle in which a write's data is expected on `dq_i`.
- R10: After reset, `dq_en` is low, `dq_o` is zero and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| sel | input | 1 | Synchronous select; low makes the cycle a no-op |
| pd | input | 1 | Synchronous power-down |
| we_all | input | 1 | Global write enable, writes every lane |
| we_lane | input | LANES | Per-lane write enables |
| addr | input | AW | Word address |
| oe | input | 1 | Asynchronous output enable |
| dq_i | input | LANES*LANE_W | Write data, one cycle after its address |
| dq_o | output | LANES*LANE_W | Output register contents |
| dq_en | output | 1 | High when the bus should be driven from `dq_o` |

## Verification
Two functions can fall on the same edge. One is the capture of a late write's data into the buffer. The other is a read of that same address, which must take the just-captured lanes from the buffer instead of the array. The bench provokes this with directed write-then-read pairs, including partial-lane writes. It also keeps a random stream on eight addresses going, so that the pairing happens often. Its reference model applies each write's data to a plain word array before the read that follows it is served. Every cycle it compares `dq_en` and `dq_o` against what that array predicts.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
   typedef enum logic [1:0] {
      OP_NOP = 2'd0,
      OP_RD  = 2'd1,
      OP_WR  = 2'd2
   } op_e;
endpackage

// File: rtl/lw_sram_cmd.sv
module lw_sram_cmd
   import lw_sram_pkg::*;
#(
   parameter int LANES = 4,
   parameter int AW    = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             pd,
   input  logic             we_all,
   input  logic [LANES-1:0] we_lane,
   input  logic [AW-1:0]    addr,
   output op_e              op_q,
   output logic [AW-1:0]    addr_q,
   output logic [LANES-1:0] mask_q,
   output logic             pd_q
);
   op_e              op_d;
   logic [LANES-1:0] mask_d;

   // decode of the sampled command (R1)
   always_comb begin
      if (!sel || pd)
         op_d = OP_NOP;
      else if (we_all || (|we_lane))
         op_d = OP_WR;
      else
         op_d = OP_RD;
      mask_d = we_all ? {LANES{1'b1}} : we_lane;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q   <= OP_NOP;
         addr_q <= '0;
         mask_q <= '0;
         pd_q   <= 1'b0;
      end else begin
         op_q   <= op_d;
         addr_q <= addr;
         mask_q <= mask_d;
         pd_q   <= pd;
      end
   end

   assert_wr_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_WR) |-> (mask_q != '0));
   assert_pd_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pd_q |-> (op_q == OP_NOP));
endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf
   import lw_sram_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int AW     = 9,
   localparam int W     = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  op_e              op_q,
   input  logic [AW-1:0]    addr_q,
   input  logic [LANES-1:0] mask_q,
   input  logic             pd_q,
   input  logic [W-1:0]     din,
   output logic             wb_valid,
   output logic [AW-1:0]    wb_addr,
   output logic [W-1:0]     wb_data,
   output logic [LANES-1:0] wb_mask,
   output logic             commit
);
   logic load;

   // the array port is free unless a read needs it; a new write always drains
   assign load   = (op_q == OP_WR);
   assign commit = wb_valid && (load || ((op_q == OP_NOP) && !pd_q));

   always_ff @(posedge clk) begin
      if (!rst_n)
         wb_valid <= 1'b0;
      else if (load)
         wb_valid <= 1'b1;
      else if (commit)
         wb_valid <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (load) begin
         wb_addr <= addr_q;
         wb_data <= din;
         wb_mask <= mask_q;
      end
   end

   assert_no_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && load) |-> commit);
   assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !commit && !load) |=> (wb_valid && $stable(wb_data) && $stable(wb_addr)));
   assert_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (wb_mask != '0));
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
   parameter int DEPTH  = 512,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int AW    = $clog2(DEPTH),
   localparam int W     = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             we,
   input  logic [LANES-1:0] wmask,
   input  logic [AW-1:0]    waddr,
   input  logic [W-1:0]     wdata,
   input  logic [AW-1:0]    raddr,
   output logic [W-1:0]     rdata
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wmask[g])
            mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
   end
endmodule

// File: rtl/lw_sram_rdout.sv
module lw_sram_rdout
   import lw_sram_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int AW     = 9,
   localparam int W     = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  op_e              op_q,
   input  logic [AW-1:0]    addr_q,
   input  logic             pd_q,
   input  logic [W-1:0]     arr_q,
   input  logic             wb_valid,
   input  logic [AW-1:0]    wb_addr,
   input  logic [W-1:0]     wb_data,
   input  logic [LANES-1:0] wb_mask,
   input  logic             oe,
   output logic [W-1:0]     q,
   output logic             dq_en
);
   logic         hit;
   logic [W-1:0] merged;
   logic         q_valid;

   assign hit = wb_valid && (wb_addr == addr_q);

   // forwarding from the pending late write, lane by lane (R5)
   for (genvar g = 0; g < LANES; g++) begin : g_fwd
      assign merged[g*LANE_W +: LANE_W] = (hit && wb_mask[g]) ?
         wb_data[g*LANE_W +: LANE_W] : arr_q[g*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q       <= '0;
         q_valid <= 1'b0;
      end else begin
         q_valid <= (op_q == OP_RD);
         if (op_q == OP_RD)
            q <= merged;
      end
   end

   // asynchronous in oe; never drives while write data is due
   assign dq_en = oe && q_valid && !pd_q && (op_q != OP_WR);

   assert_rd_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_RD) |=> q_valid);
   assert_nop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q != OP_RD) |=> ($stable(q) && !q_valid));
   assert_oe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> !dq_en);
endmodule

// File: rtl/lw_sram.sv
module lw_sram
   import lw_sram_pkg::*;
#(
   parameter int DEPTH  = 512,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int AW    = $clog2(DEPTH),
   localparam int W     = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             pd,
   input  logic             we_all,
   input  logic [LANES-1:0] we_lane,
   input  logic [AW-1:0]    addr,
   input  logic             oe,
   input  logic [W-1:0]     dq_i,
   output logic [W-1:0]     dq_o,
   output logic             dq_en
);
   if (DEPTH < 2 || LANES < 1 || LANE_W < 1) begin : g_bad_cfg
      $error("lw_sram: DEPTH must be >= 2 and lanes must be non-empty");
   end
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("lw_sram: DEPTH must be a power of two");
   end

   op_e              op_q;
   logic [AW-1:0]    addr_q;
   logic [LANES-1:0] mask_q;
   logic             pd_q;
   logic             wb_valid;
   logic [AW-1:0]    wb_addr;
   logic [W-1:0]     wb_data;
   logic [LANES-1:0] wb_mask;
   logic             commit;
   logic [W-1:0]     arr_q;

   lw_sram_cmd #(.LANES(LANES), .AW(AW)) u_cmd (
      .clk(clk), .rst_n(rst_n), .sel(sel), .pd(pd), .we_all(we_all),
      .we_lane(we_lane), .addr(addr), .op_q(op_q), .addr_q(addr_q),
      .mask_q(mask_q), .pd_q(pd_q)
   );

   lw_sram_wbuf #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_wbuf (
      .clk(clk), .rst_n(rst_n), .op_q(op_q), .addr_q(addr_q), .mask_q(mask_q),
      .pd_q(pd_q), .din(dq_i), .wb_valid(wb_valid), .wb_addr(wb_addr),
      .wb_data(wb_data), .wb_mask(wb_mask), .commit(commit)
   );

   lw_sram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk(clk), .we(commit), .wmask(wb_mask), .waddr(wb_addr),
      .wdata(wb_data), .raddr(addr_q), .rdata(arr_q)
   );

   lw_sram_rdout #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_rdout (
      .clk(clk), .rst_n(rst_n), .op_q(op_q), .addr_q(addr_q), .pd_q(pd_q),
      .arr_q(arr_q), .wb_valid(wb_valid), .wb_addr(wb_addr),
      .wb_data(wb_data), .wb_mask(wb_mask), .oe(oe), .q(dq_o), .dq_en(dq_en)
   );

   assert_wr_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_WR) |-> !dq_en);
   assert_pd_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pd_q |-> (!dq_en && !commit));
   assert_port_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (op_q != OP_RD));
   assert_reset_R10: assert property (@(posedge clk)
      !rst_n |=> (!wb_valid && !dq_en));
endmodule

// File: tb/sim_lw_sram.sv
`timescale 1ns/1ps
module sim_lw_sram;
   localparam int DEPTH  = 512;
   localparam int LANES  = 4;
   localparam int LANE_W = 9;
   localparam int W      = LANES * LANE_W;
   localparam int AW     = $clog2(DEPTH);

   logic             clk = 1'b0;
   logic             rst_n;
   logic             sel, pd, we_all, oe;
   logic [LANES-1:0] we_lane;
   logic [AW-1:0]    addr;
   logic [W-1:0]     dq_i;
   logic [W-1:0]     dq_o;
   logic             dq_en;

   always #10 clk = ~clk;

   lw_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u0 (
      .clk(clk), .rst_n(rst_n), .sel(sel), .pd(pd), .we_all(we_all),
      .we_lane(we_lane), .addr(addr), .oe(oe), .dq_i(dq_i),
      .dq_o(dq_o), .dq_en(dq_en)
   );

   int         n_checks = 0;
   int         n_fail   = 0;
   string      tag      = "R2";
   // reference: plain word array, previous command, expected output
   logic [W-1:0] ref_mem [16];
   int           prev_kind = 0;   // 0 nop, 1 read, 2 write
   int           prev_addr = 0;
   logic [3:0]   prev_mask = '0;
   logic         exp_valid = 1'b0;
   logic [W-1:0] exp_q     = '0;
   logic         exp_pd    = 1'b0;

   task automatic chk(string t, logic [W-1:0] act, logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", t, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
   endtask

   task automatic compare();
      logic  want_en;
      string t;
      want_en = oe && exp_valid && !exp_pd && (prev_kind != 2);
      if (want_en) begin
         chk(tag, W'(dq_en), W'(1));
         chk(tag, dq_o, exp_q);
      end else begin
         if (exp_pd)              t = "R8";
         else if (prev_kind == 2) t = "R9";
         else if (!oe)            t = "R6";
         else                     t = "R7";
         chk(t, W'(dq_en), W'(0));
         chk(t, dq_o, exp_q);     // output register holds its value
      end
   endtask

   // one clock: check at the falling edge, drive, model the rising edge
   task automatic cyc(bit s, bit p, bit wa, logic [3:0] wl, int a,
                      logic [W-1:0] d, bit o);
      int kind;
      compare();
      sel = s; pd = p; we_all = wa; we_lane = wl; addr = AW'(a); dq_i = d; oe = o;
      @(posedge clk);
      if (prev_kind == 2)
         for (int l = 0; l < LANES; l++)
            if (prev_mask[l]) ref_mem[prev_addr][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
      if (prev_kind == 1) begin
         exp_q     = ref_mem[prev_addr];
         exp_valid = 1'b1;
      end else begin
         exp_valid = 1'b0;
      end
      if (!s || p)              kind = 0;
      else if (wa || (wl != 0)) kind = 2;
      else                      kind = 1;
      prev_kind = kind;
      prev_addr = a;
      prev_mask = wa ? 4'hF : wl;
      exp_pd    = p;
      @(negedge clk);
   endtask

   function automatic logic [W-1:0] rnd_word();
      return W'({$urandom(), $urandom()});
   endfunction

   task automatic rd(int a);                        cyc(1, 0, 0, 4'h0, a, rnd_word(), 1); endtask
   task automatic nop(logic [W-1:0] d);             cyc(0, 0, 0, 4'h0, 0, d, 1);          endtask
   task automatic wr(int a, bit wa, logic [3:0] m, logic [W-1:0] d);
      cyc(1, 0, wa, m, a, d, 1);
   endtask

   initial begin
      #(20.0 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      summary();
      $finish;
   end

   initial begin
      logic [W-1:0] w0, w1;
      rst_n = 1'b0; sel = 0; pd = 0; we_all = 0; we_lane = '0; addr = '0; dq_i = '0; oe = 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state
      chk("R10", W'(dq_en), W'(0));
      chk("R10", dq_o, '0);

      // fill the 16-word window with global writes (data lags one cycle)
      w0 = rnd_word();
      for (int a = 0; a < 16; a++) begin
         wr(a, 1, 4'h0, w0);
         w0 = rnd_word();
      end
      nop(w0);
      tag = "R2";
      for (int a = 0; a < 16; a++) rd(a);
      nop('0);

      // R6: output enable gates the bus between edges
      rd(2);
      rd(2);
      oe = 1'b0; #1;
      chk("R6", W'(dq_en), W'(0));
      oe = 1'b1; #1;
      chk("R6", W'(dq_en), W'(1));

      // R5: read directly after a write to the same address
      tag = "R5";
      w1 = rnd_word();
      wr(3, 1, 4'h0, rnd_word());
      cyc(1, 0, 0, 4'h0, 3, w1, 1);   // read 3 while its data arrives
      rd(3);
      nop('0);
      // R4: partial lanes, then a global write ignoring lane bits
      tag = "R4";
      wr(5, 0, 4'b0101, rnd_word());
      cyc(1, 0, 0, 4'h0, 5, rnd_word(), 1);
      wr(6, 1, 4'b0001, rnd_word());
      cyc(1, 0, 0, 4'h0, 6, rnd_word(), 1);
      rd(5);
      rd(6);
      // R9: read then write, bus must release during the data cycle
      tag = "R9";
      rd(9);
      wr(9, 0, 4'b1000, rnd_word());
      rd(9);
      rd(9);
      // R7: deselected cycles hold the output register
      tag = "R7";
      rd(4);
      nop('0);
      nop('0);
      rd(4);
      // R8: power-down with a pending write and ignored commands
      tag = "R8";
      wr(7, 1, 4'h0, rnd_word());
      cyc(1, 1, 0, 4'h0, 7, rnd_word(), 1);
      cyc(1, 1, 1, 4'h0, 8, rnd_word(), 1);
      cyc(1, 1, 0, 4'h0, 8, rnd_word(), 1);
      cyc(0, 1, 0, 4'h0, 0, rnd_word(), 1);
      rd(7);
      rd(8);
      nop('0);

      // R1: random interleaved traffic on eight addresses
      tag = "R1";
      for (int i = 0; i < 4000; i++) begin
         int  r;
         bit  s, p, wa;
         logic [3:0] m;
         r  = $urandom_range(0, 99);
         s  = (r < 92);
         p  = ($urandom_range(0, 99) < 4);
         wa = 0;
         m  = '0;
         if ($urandom_range(0, 99) < 40) begin
            wa = $urandom_range(0, 1) == 1;
            m  = 4'($urandom_range(1, 15));
         end
         cyc(s, p, wa, m, $urandom_range(0, 7), rnd_word(), $urandom_range(0, 99) < 85);
      end
      nop('0);
      nop('0);
      compare();
      summary();
      $finish;
   end
endmodule